// File: doc/BRIEF.md
# Wiper and Comparator Control Register Bank

This block holds the settings for two wiper channels and two comparator-control channels. Every channel has one volatile working register and four stored data slots, each six bits wide. A single command port reads or writes the working register or any stored slot. It also copies between a slot and the working register in either direction, and steps a wiper up or down by one position. Each wiper's working value is decoded into a one-hot select over 64 taps. Each comparator channel gates an incoming raw comparator bit according to its power, enable and latch bits.

Any change to a stored slot is modelled as a slow commit. The bank stays busy for `BUSY_CYCLES` clocks, and commands arriving in that time are dropped with an error pulse. An active-low write-protect input refuses every stored-slot change. At reset, the stored slots take parameterised values and every working register starts from its slot 0 value.

Top module: `wiper_ctrl_bank`

## Requirements
- R1: `tap_sel0`/`tap_sel1` have exactly one bit set, at the index equal to the channel 0/1 wiper value; 0x00 selects bit 0 (low end) and 0x3F selects bit 63 (high end).
- R2: After reset, stored slot 0 of channels 0 and 1 holds `INIT_WIPER`, slot 0 of channels 2 and 3 holds `INIT_CTRL`, and slots 1 to 3 hold 0. Each working register equals its slot 0, and `busy` is 0.
- R3: The command ops are 0 read working, 1 write working, 2 read slot, 3 write slot, 4 load slot into working, 5 save working into slot, 6 increment and 7 decrement. `cmd_chan` 0 and 1 are wipers and 2 and 3 are controls. An accepted write working updates the register at the edge. An accepted read drives `rd_data` = {2'b00, value} from the next cycle; bits 7:6 always read 0.
- R4: Load copies slot `cmd_reg` of the channel into its working register. Save copies the working register into slot `cmd_reg`.
- R5: Increment and decrement change a wiper by one. At 0x3F an increment, and at 0x00 a decrement, leave it unchanged. On channels 2 and 3 they change nothing and pulse `cmd_err` one cycle later.
- R6: With `wp_n` = 0, write slot and save change no slot, start no busy interval, and pulse `cmd_err` one cycle later.
- R7: An accepted slot change raises `busy` from the next cycle for exactly `BUSY_CYCLES` cycles. A command presented while `busy` is 1 is dropped with no effect and pulses `cmd_err` one cycle later.
- R8: In a control value, bit 0 = 1 means powered, bit 1 = 1 means enabled and bit 2 = 1 means latched. `cmp_out[j]` is 0 unless the channel is both powered and enabled. Unlatched, it follows `cmp_raw[j]` in the same cycle. Latched, it holds the raw value sampled at the last edge before the latch bit took effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_chan | input | 2 | Channel: 0,1 wiper; 2,3 control |
| cmd_reg | input | 2 | Stored slot index |
| cmd_data | input | 6 | Write data |
| wp_n | input | 1 | Active-low write protect for stored slots |
| cmp_raw | input | 2 | Raw comparator results, one per control channel |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | Stored-slot commit in progress |
| cmd_err | output | 1 | One-cycle pulse for a refused or dropped command |
| tap_sel0 | output | 64 | One-hot tap select, wiper 0 |
| tap_sel1 | output | 64 | One-hot tap select, wiper 1 |
| cmp_out | output | 2 | Gated comparator outputs |

## Verification
Working-register changes, and through them `tap_sel0`/`tap_sel1`, are due right after the accepting edge. `rd_data` and `cmd_err` are due in the cycle after that edge. `cmp_out` follows `cmp_raw` combinationally while unlatched. The bench drives every command on a falling edge and samples on the next falling edge, half a period after the accepting edge, so that each check lands on the cycle its result becomes valid. The busy length is measured by counting falling edges while `busy` is high, right after the accepting edge.

// File: rtl/wiper_ctrl_bank.sv
module wiper_ctrl_bank #(
  parameter int       BUSY_CYCLES = 500000,
  parameter bit [5:0] INIT_WIPER  = 6'h20,
  parameter bit [5:0] INIT_CTRL   = 6'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [1:0]  cmd_chan,
  input  logic [1:0]  cmd_reg,
  input  logic [5:0]  cmd_data,
  input  logic        wp_n,
  input  logic [1:0]  cmp_raw,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic        cmd_err,
  output logic [63:0] tap_sel0,
  output logic [63:0] tap_sel1,
  output logic [1:0]  cmp_out
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [2:0] OP_RDW = 3'd0, OP_WRW = 3'd1, OP_RDS = 3'd2, OP_WRS = 3'd3,
                         OP_LOAD = 3'd4, OP_SAVE = 3'd5, OP_INC = 3'd6, OP_DEC = 3'd7;

  logic [5:0]    st [4][4];
  logic [5:0]    wk [4];
  logic [CW-1:0] cnt;
  logic [1:0]    held;
  logic          go;

  assign busy     = (cnt != '0);
  assign go       = cmd_valid && !busy;
  assign tap_sel0 = 64'd1 << wk[0];
  assign tap_sel1 = 64'd1 << wk[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < 4; s++) st[c][s] <= (s == 0) ? (c < 2 ? INIT_WIPER : INIT_CTRL) : 6'd0;
        wk[c] <= (c < 2) ? INIT_WIPER : INIT_CTRL;
      end
      cnt     <= '0;
      cmd_err <= 1'b0;
      rd_data <= 8'd0;
    end else begin
      cmd_err <= 1'b0;
      if (busy) cnt <= cnt - 1'b1;
      if (cmd_valid && busy) cmd_err <= 1'b1;
      else if (go) begin
        case (cmd_op)
          OP_RDW:  rd_data <= {2'b00, wk[cmd_chan]};
          OP_RDS:  rd_data <= {2'b00, st[cmd_chan][cmd_reg]};
          OP_WRW:  wk[cmd_chan] <= cmd_data;
          OP_LOAD: wk[cmd_chan] <= st[cmd_chan][cmd_reg];
          OP_WRS, OP_SAVE:
            if (wp_n) begin
              st[cmd_chan][cmd_reg] <= (cmd_op == OP_WRS) ? cmd_data : wk[cmd_chan];
              cnt <= CW'(BUSY_CYCLES);
            end else cmd_err <= 1'b1;
          OP_INC:
            if (cmd_chan[1]) cmd_err <= 1'b1;
            else if (wk[cmd_chan] != 6'h3F) wk[cmd_chan] <= wk[cmd_chan] + 6'd1;
          OP_DEC:
            if (cmd_chan[1]) cmd_err <= 1'b1;
            else if (wk[cmd_chan] != 6'h00) wk[cmd_chan] <= wk[cmd_chan] - 6'd1;
          default: ;
        endcase
      end
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_cmp
    logic pw, en, la;
    assign pw = wk[2+j][0];
    assign en = wk[2+j][1];
    assign la = wk[2+j][2];
    always_ff @(posedge clk) begin
      if (!rst_n)   held[j] <= 1'b0;
      else if (!pw) held[j] <= 1'b0;
      else if (!la) held[j] <= cmp_raw[j];
    end
    assign cmp_out[j] = pw & en & (la ? held[j] : cmp_raw[j]);
  end

  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_INC && cmd_chan == 2'd0 && wk[0] == 6'h3F) |=> (wk[0] == 6'h3F));
  p_sat_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_DEC && cmd_chan == 2'd1 && wk[1] == 6'h00) |=> (wk[1] == 6'h00));
  p_wp_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wp_n && (cmd_op == OP_WRS || cmd_op == OP_SAVE)) |=> (cmd_err && !busy));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> cmd_err);
  p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go && wp_n && (cmd_op == OP_WRS || cmd_op == OP_SAVE)));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_LOAD && cmd_chan == 2'd0) |=> (wk[0] == $past(st[0][cmd_reg])));
endmodule

// File: tb/tb_wiper_ctrl_bank.sv
`timescale 1ns/1ps
module tb_wiper_ctrl_bank;
  localparam int BUSY = 5;
  logic clk = 0, rst_n = 0, cmd_valid = 0, wp_n = 1;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_chan = 0, cmd_reg = 0, cmp_raw = 0;
  logic [5:0] cmd_data = 0;
  logic [7:0] rd_data;
  logic busy, cmd_err;
  logic [63:0] tap_sel0, tap_sel1;
  logic [1:0] cmp_out;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wiper_ctrl_bank #(.BUSY_CYCLES(BUSY), .INIT_WIPER(6'h15), .INIT_CTRL(6'h03)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_chan(cmd_chan),
    .cmd_reg(cmd_reg), .cmd_data(cmd_data), .wp_n(wp_n), .cmp_raw(cmp_raw), .rd_data(rd_data),
    .busy(busy), .cmd_err(cmd_err), .tap_sel0(tap_sel0), .tap_sel1(tap_sel1), .cmp_out(cmp_out));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] ch, input logic [1:0] rg, input logic [5:0] d);
    cmd_valid = 1; cmd_op = op; cmd_chan = ch; cmd_reg = rg; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rdw(input logic [1:0] ch, input logic [7:0] exp, input string tag);
    cmd(3'd0, ch, 2'd0, 6'd0);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic rds(input logic [1:0] ch, input logic [1:0] rg, input logic [7:0] exp, input string tag);
    cmd(3'd2, ch, rg, 6'd0);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(busy == 0, "R2 busy after reset", busy, 0);
    chk(tap_sel0 == (64'd1 << 6'h15), "R2 R1 reset tap0", tap_sel0, 64'd1 << 6'h15);
    rdw(2'd0, 8'h15, "R2 work0");
    rdw(2'd1, 8'h15, "R2 work1");
    rdw(2'd2, 8'h03, "R2 work2");
    rdw(2'd3, 8'h03, "R2 work3");
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        rds(c[1:0], s[1:0], (s == 0) ? ((c < 2) ? 8'h15 : 8'h03) : 8'h00, "R2 stored");

    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 64; p++) begin
        cmd(3'd1, c[1:0], 2'd0, p[5:0]);
        if (c == 0) chk(tap_sel0 == (64'd1 << p), "R1 tap0", tap_sel0, 64'd1 << p);
        else        chk(tap_sel1 == (64'd1 << p), "R1 tap1", tap_sel1, 64'd1 << p);
        rdw(c[1:0], {2'b00, p[5:0]}, "R3 readback");
      end
    cmd(3'd1, 2'd3, 2'd0, 6'h3F);
    rdw(2'd3, 8'h3F, "R3 ctrl upper bits zero");

    cmd(3'd3, 2'd1, 2'd2, 6'h2A);
    chk(busy == 1, "R7 busy raised", busy, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == BUSY, "R7 busy length", n, BUSY);
    cmd(3'd4, 2'd1, 2'd2, 6'd0);
    rdw(2'd1, 8'h2A, "R4 load");
    cmd(3'd1, 2'd0, 2'd0, 6'h11);
    cmd(3'd5, 2'd0, 2'd3, 6'd0);
    cmd(3'd1, 2'd0, 2'd0, 6'h07);
    chk(cmd_err == 1, "R7 drop err", cmd_err, 1);
    idle();
    rdw(2'd0, 8'h11, "R7 dropped write no effect");
    rds(2'd0, 2'd3, 8'h11, "R4 save");

    wp_n = 0;
    cmd(3'd3, 2'd0, 2'd1, 6'h3C);
    chk(cmd_err == 1 && busy == 0, "R6 wp write refused", {cmd_err, busy}, 2'b10);
    cmd(3'd5, 2'd0, 2'd2, 6'd0);
    chk(cmd_err == 1 && busy == 0, "R6 wp save refused", {cmd_err, busy}, 2'b10);
    rds(2'd0, 2'd1, 8'h00, "R6 slot1 unchanged");
    rds(2'd0, 2'd2, 8'h00, "R6 slot2 unchanged");
    wp_n = 1;

    cmd(3'd1, 2'd0, 2'd0, 6'd0);
    for (int p = 1; p < 64; p++) begin
      cmd(3'd6, 2'd0, 2'd0, 6'd0);
      chk(tap_sel0 == (64'd1 << p), "R5 inc step", tap_sel0, 64'd1 << p);
    end
    cmd(3'd6, 2'd0, 2'd0, 6'd0);
    chk(tap_sel0[63] == 1, "R5 inc saturate", tap_sel0, 64'd1 << 63);
    cmd(3'd1, 2'd1, 2'd0, 6'd3);
    for (int p = 2; p >= 0; p--) begin
      cmd(3'd7, 2'd1, 2'd0, 6'd0);
      chk(tap_sel1 == (64'd1 << p), "R5 dec step", tap_sel1, 64'd1 << p);
    end
    cmd(3'd7, 2'd1, 2'd0, 6'd0);
    chk(tap_sel1 == 64'd1, "R5 dec saturate", tap_sel1, 64'd1);
    cmd(3'd6, 2'd2, 2'd0, 6'd0);
    chk(cmd_err == 1, "R5 inc on ctrl err", cmd_err, 1);
    cmd(3'd1, 2'd2, 2'd0, 6'h05);
    cmd(3'd6, 2'd2, 2'd0, 6'd0);
    rdw(2'd2, 8'h05, "R5 ctrl unchanged");

    for (int v = 0; v < 8; v++)
      for (int r = 0; r < 2; r++) begin
        bit pw, en, la, e;
        pw = v[0]; en = v[1]; la = v[2];
        cmp_raw[0] = r[0];
        cmd(3'd1, 2'd2, 2'd0, 6'd0);
        cmd(3'd1, 2'd2, 2'd0, 6'd1);
        cmd(3'd1, 2'd2, 2'd0, {3'b000, v[2:0]});
        #1;
        e = pw & en & r[0];
        chk(cmp_out[0] == e, "R8 gate", cmp_out[0], e);
        cmp_raw[0] = ~r[0];
        #1;
        e = pw & en & (la ? r[0] : ~r[0]);
        chk(cmp_out[0] == e, "R8 latch/follow", cmp_out[0], e);
        @(negedge clk);
        chk(cmp_out[0] == e, "R8 hold next cycle", cmp_out[0], e);
      end

    finish_run();
  end
endmodule